// File: doc/BRIEF.md
# Configurable pixel component extractor

This block turns raw packed framebuffer words into an 8-bit-per-channel RGB stream. Each incoming word carries one pixel whose size in bytes is programmed. Three independent channel selectors say where that channel's bits start, how many bits it has, and which value to show when there is no usable pixel data. The extracted field is widened to 8 bits by repeating its top bits, or cut down to its top 8 bits when the field is wider than 8.

Whenever the pixel is outside the visible area, when the upstream fetch has run dry (underrun), or when a channel's width is programmed as zero, that channel's default value is shown instead of pixel data. Programming a red default of 0xFF and zero for green and blue makes underruns show up on screen as solid red. The result is registered once and leaves the block with its valid flag.

Top module: `pixel_unpacker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `out_rgb` are cleared to zero after that edge.
- R2: Each channel selector is 17 bits: bits 4:0 give the lowest source bit, bits 8:5 the field width in bits, bits 16:9 the default value. `out_rgb` packs red in bits 23:16, green in 15:8 and blue in 7:0.
- R3: A channel whose width field is zero outputs its default value, whatever the pixel word and the other channels hold.
- R4: When `in_visible` is low, all three channels output their default values.
- R5: When `in_underrun` is high, all three channels output their default values; with a red default of 0xFF and other defaults of zero the output is 0xFF0000.
- R6: `cfg_bytes_m1` holds the pixel size in bytes minus one (0 means one byte); source bits at or above 8*(cfg_bytes_m1+1) read as zero, as do bit positions beyond the word.
- R7: A field narrower than 8 bits is placed in the top bits of the output and its bits are repeated, most significant first, to fill the lower bits (a 5-bit field 10000 gives 0x84; 11111 gives 0xFF).
- R8: A field wider than 8 bits outputs its 8 most significant bits.
- R9: `out_valid` equals `in_valid` delayed by one clock, and the data for a pixel accepted at an edge appears on `out_rgb` after that same edge, so back-to-back pixels flow at one per cycle.
- R10: When `in_valid` is low at an edge, `out_rgb` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bytes_m1 | input | 2 | Pixel size in bytes minus one |
| cfg_sel_red | input | 17 | Red selector: default, width, lowest bit |
| cfg_sel_green | input | 17 | Green selector: default, width, lowest bit |
| cfg_sel_blue | input | 17 | Blue selector: default, width, lowest bit |
| in_valid | input | 1 | Pixel word present this cycle |
| in_word | input | 32 | Packed pixel word |
| in_visible | input | 1 | Pixel lies inside the visible area |
| in_underrun | input | 1 | Upstream data is missing for this pixel |
| out_valid | output | 1 | Output pixel present |
| out_rgb | output | 24 | Red, green, blue components |

## Verification
Default substitution and field extraction meet in one cycle whenever a pixel hits a zero-width channel or a blanking/underrun flag while the other channels still carry data. The bench provokes this by sending pixels with one channel at width zero, then the same pixels with underrun and blanking raised together, and by streaming back-to-back pixels that alternate between substituted and extracted values. Each output is judged against a bit-by-bit model that picks every output bit from its source index, so a channel that leaks data into a substituted neighbour, or keeps a default after the flag drops, shows up in the very next cycle.

// File: rtl/pxu_pkg.sv
// Shared constants for the pixel unpacker.
// Assumes the pixel word is a whole number of bytes.
package pxu_pkg;
    localparam int BYTE_W = 8;
    localparam int CHANNELS = 3;
    localparam int CH_RED = 0;
    localparam int CH_GREEN = 1;
    localparam int CH_BLUE = 2;
endpackage

// File: rtl/pxu_lane_mask.sv
// Keeps only the low byte lanes that belong to the current pixel size
// and forces every higher lane to zero.
// Assumes WORD_W is a multiple of 8.
module pxu_lane_mask #(
    parameter int WORD_W = 32,
    localparam int LANES = WORD_W / pxu_pkg::BYTE_W,
    localparam int BM_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [BM_W-1:0]   bytes_m1,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // pass lane l only when it lies inside the pixel
        assign word_out[l*pxu_pkg::BYTE_W +: pxu_pkg::BYTE_W] =
            (int'(bytes_m1) >= l) ? word_in[l*pxu_pkg::BYTE_W +: pxu_pkg::BYTE_W]
                                  : '0;
    end
endmodule

// File: rtl/pxu_field_pick.sv
// Shifts the selected field down, then returns it left-aligned in COMP_W
// bits together with the effective width (saturated at COMP_W).
// Wide fields keep their top COMP_W bits. Assumes COMP_W < 2**LEN_W.
module pxu_field_pick #(
    parameter int WORD_W = 32,
    parameter int COMP_W = 8,
    parameter int LEN_W = 4,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [OFF_W-1:0]  off,
    input  logic [LEN_W-1:0]  len,
    output logic [COMP_W-1:0] picked,
    output logic [LEN_W-1:0]  eff_len
);
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] low_bits;
    logic [WORD_W-1:0] aligned;

    // align the field, then trim or left-justify it
    always_comb begin
        shifted  = word >> off;
        low_bits = shifted & ~({WORD_W{1'b1}} << len);
        if (int'(len) >= COMP_W) begin
            aligned = shifted >> (int'(len) - COMP_W);
            eff_len = LEN_W'(COMP_W);
        end else begin
            aligned = low_bits << (COMP_W - int'(len));
            eff_len = len;
        end
        picked = aligned[COMP_W-1:0];
    end
endmodule

// File: rtl/pxu_bit_fill.sv
// Fills the low bits below a left-aligned field by repeating the field,
// most significant bit first, so the full COMP_W range is reached.
// A zero width yields zero (the caller substitutes the default).
module pxu_bit_fill #(
    parameter int COMP_W = 8,
    parameter int LEN_W = 4
) (
    input  logic [COMP_W-1:0] picked,
    input  logic [LEN_W-1:0]  eff_len,
    output logic [COMP_W-1:0] filled
);
    // OR together copies of the field shifted by multiples of its width
    always_comb begin
        filled = '0;
        if (eff_len != '0) begin
            for (int k = 0; k < COMP_W; k++) begin
                filled = filled | (picked >> (k * int'(eff_len)));
            end
        end
    end
endmodule

// File: rtl/pxu_channel.sv
// One colour channel: decodes its selector, extracts and widens the field,
// and substitutes the default on zero width or when forced.
// Selector layout: {default[COMP_W], width[LEN_W], lowest_bit[OFF_W]}.
module pxu_channel #(
    parameter int WORD_W = 32,
    parameter int COMP_W = 8,
    parameter int LEN_W = 4,
    localparam int OFF_W = $clog2(WORD_W),
    localparam int SEL_W = COMP_W + LEN_W + OFF_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    input  logic              force_dflt,
    output logic [COMP_W-1:0] comp
);
    logic [OFF_W-1:0]  off;
    logic [LEN_W-1:0]  len;
    logic [COMP_W-1:0] dflt;
    logic [COMP_W-1:0] picked;
    logic [LEN_W-1:0]  eff_len;
    logic [COMP_W-1:0] filled;

    assign off  = sel[OFF_W-1:0];
    assign len  = sel[OFF_W +: LEN_W];
    assign dflt = sel[OFF_W+LEN_W +: COMP_W];

    pxu_field_pick #(
        .WORD_W(WORD_W), .COMP_W(COMP_W), .LEN_W(LEN_W)
    ) u_pick (
        .word(word), .off(off), .len(len),
        .picked(picked), .eff_len(eff_len)
    );

    pxu_bit_fill #(
        .COMP_W(COMP_W), .LEN_W(LEN_W)
    ) u_fill (
        .picked(picked), .eff_len(eff_len), .filled(filled)
    );

    // choose the default or the widened field
    always_comb begin
        if (force_dflt || (len == '0)) comp = dflt;
        else                           comp = filled;
    end
endmodule

// File: rtl/pixel_unpacker.sv
// Top of the pixel unpacker: masks the word to the pixel size, runs three
// channel extractors in parallel and registers the packed RGB result with
// its valid flag (one cycle of latency). Data holds while valid is low.
// Assumes configuration is stable while pixels flow.
module pixel_unpacker #(
    parameter int WORD_W = 32,
    parameter int COMP_W = 8,
    parameter int LEN_W = 4,
    localparam int LANES = WORD_W / pxu_pkg::BYTE_W,
    localparam int BM_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int OFF_W = $clog2(WORD_W),
    localparam int SEL_W = COMP_W + LEN_W + OFF_W,
    localparam int RGB_W = pxu_pkg::CHANNELS * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BM_W-1:0]   cfg_bytes_m1,
    input  logic [SEL_W-1:0]  cfg_sel_red,
    input  logic [SEL_W-1:0]  cfg_sel_green,
    input  logic [SEL_W-1:0]  cfg_sel_blue,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_visible,
    input  logic              in_underrun,
    output logic              out_valid,
    output logic [RGB_W-1:0]  out_rgb
);
    logic [WORD_W-1:0] masked;
    logic              force_dflt;
    logic [SEL_W-1:0]  sel_arr  [pxu_pkg::CHANNELS];
    logic [COMP_W-1:0] comp_arr [pxu_pkg::CHANNELS];
    logic [RGB_W-1:0]  rgb_next;

    assign sel_arr[pxu_pkg::CH_RED]   = cfg_sel_red;
    assign sel_arr[pxu_pkg::CH_GREEN] = cfg_sel_green;
    assign sel_arr[pxu_pkg::CH_BLUE]  = cfg_sel_blue;
    assign force_dflt = !in_visible || in_underrun;

    pxu_lane_mask #(.WORD_W(WORD_W)) u_mask (
        .bytes_m1(cfg_bytes_m1), .word_in(in_word), .word_out(masked)
    );

    for (genvar c = 0; c < pxu_pkg::CHANNELS; c++) begin : g_chan
        pxu_channel #(
            .WORD_W(WORD_W), .COMP_W(COMP_W), .LEN_W(LEN_W)
        ) u_chan (
            .word(masked), .sel(sel_arr[c]),
            .force_dflt(force_dflt), .comp(comp_arr[c])
        );
        // red lands in the top component slot, blue in the bottom one
        assign rgb_next[(pxu_pkg::CHANNELS-1-c)*COMP_W +: COMP_W] = comp_arr[c];
    end

    // output register: valid follows input, data loads only on valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_rgb <= rgb_next;
        end
    end
endmodule

// File: rtl/pxu_checker.sv
// Temporal checks on the pixel unpacker ports, bound to every instance.
module pxu_checker #(
    parameter int WORD_W = 32,
    parameter int COMP_W = 8,
    parameter int LEN_W = 4,
    localparam int LANES = WORD_W / 8,
    localparam int BM_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int OFF_W = $clog2(WORD_W),
    localparam int SEL_W = COMP_W + LEN_W + OFF_W,
    localparam int RGB_W = 3 * COMP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BM_W-1:0]   cfg_bytes_m1,
    input logic [SEL_W-1:0]  cfg_sel_red,
    input logic [SEL_W-1:0]  cfg_sel_green,
    input logic [SEL_W-1:0]  cfg_sel_blue,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_word,
    input logic              in_visible,
    input logic              in_underrun,
    input logic              out_valid,
    input logic [RGB_W-1:0]  out_rgb
);
    localparam int DL = OFF_W + LEN_W;

    logic [RGB_W-1:0] all_dflt;
    assign all_dflt = {cfg_sel_red[DL +: COMP_W], cfg_sel_green[DL +: COMP_W],
                       cfg_sel_blue[DL +: COMP_W]};

    p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_rgb));
    p_blank_dflt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_visible) |=> (out_rgb == $past(all_dflt)));
    p_underrun_dflt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_underrun) |=> (out_rgb == $past(all_dflt)));
    p_zero_red_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_sel_red[OFF_W +: LEN_W] == '0)
        |=> (out_rgb[2*COMP_W +: COMP_W] == $past(cfg_sel_red[DL +: COMP_W])));
    p_zero_green_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_sel_green[OFF_W +: LEN_W] == '0)
        |=> (out_rgb[COMP_W +: COMP_W] == $past(cfg_sel_green[DL +: COMP_W])));
    p_zero_blue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_sel_blue[OFF_W +: LEN_W] == '0)
        |=> (out_rgb[0 +: COMP_W] == $past(cfg_sel_blue[DL +: COMP_W])));

    logic unused_ok;
    assign unused_ok = ^{cfg_bytes_m1, in_word};
endmodule

bind pixel_unpacker pxu_checker #(
    .WORD_W(WORD_W), .COMP_W(COMP_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/pixel_unpacker_bench.sv
// Directed bench for the pixel unpacker: one task per scenario.
module pixel_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_bytes_m1 = 2'd3;
    logic [16:0] cfg_sel_red = '0, cfg_sel_green = '0, cfg_sel_blue = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_visible = 1'b1;
    logic        in_underrun = 1'b0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pixel_unpacker u_pixel_unpacker (
        .clk(clk), .rst_n(rst_n), .cfg_bytes_m1(cfg_bytes_m1),
        .cfg_sel_red(cfg_sel_red), .cfg_sel_green(cfg_sel_green),
        .cfg_sel_blue(cfg_sel_blue), .in_valid(in_valid), .in_word(in_word),
        .in_visible(in_visible), .in_underrun(in_underrun),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    function automatic logic [16:0] mk_sel(input logic [7:0] d, input int len, input int off);
        return {d, 4'(len), 5'(off)};
    endfunction

    // reference: pick each output bit straight from its source index
    function automatic logic [7:0] ref_comp(input logic [31:0] w, input int bm1,
                                            input logic [16:0] sel, input logic vis,
                                            input logic und);
        int off;
        int len;
        logic [31:0] m;
        logic [7:0] r;
        off = int'(sel[4:0]);
        len = int'(sel[8:5]);
        if (len == 0 || !vis || und) return sel[16:9];
        for (int b = 0; b < 32; b++) m[b] = (b < (bm1 + 1) * 8) ? w[b] : 1'b0;
        for (int i = 0; i < 8; i++) begin
            int j;
            int p;
            j = (len >= 8) ? (len - 1 - i) : (len - 1 - (i % len));
            p = off + j;
            r[7 - i] = (p < 32) ? m[p] : 1'b0;
        end
        return r;
    endfunction

    function automatic logic [23:0] ref_rgb(input logic [31:0] w, input logic vis,
                                            input logic und);
        return {ref_comp(w, int'(cfg_bytes_m1), cfg_sel_red, vis, und),
                ref_comp(w, int'(cfg_bytes_m1), cfg_sel_green, vis, und),
                ref_comp(w, int'(cfg_bytes_m1), cfg_sel_blue, vis, und)};
    endfunction

    task automatic check(input string tag, input logic [24:0] got, input logic [24:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got valid=%0b rgb=%06h, expected valid=%0b rgb=%06h",
                     tag, got[24], got[23:0], exp[24], exp[23:0]);
        end
    endtask

    // drive one pixel, check it one edge later, then idle
    task automatic send(input string tag, input logic [31:0] w, input logic vis,
                        input logic und, input logic [23:0] exp);
        in_valid = 1'b1; in_word = w; in_visible = vis; in_underrun = und;
        @(negedge clk);
        check(tag, {out_valid, out_rgb}, {1'b1, exp});
        in_valid = 1'b0; in_visible = 1'b1; in_underrun = 1'b0;
    endtask

    task automatic t_reset;
        in_valid = 1'b1; in_word = 32'hFFFF_FFFF;
        cfg_sel_red = mk_sel(8'h11, 8, 0);
        repeat (3) @(negedge clk);
        check("R1 reset clears outputs", {out_valid, out_rgb}, 25'h0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_layout_565;
        cfg_bytes_m1 = 2'd1;
        cfg_sel_red = mk_sel(8'h00, 5, 11);
        cfg_sel_green = mk_sel(8'h00, 6, 5);
        cfg_sel_blue = mk_sel(8'h00, 5, 0);
        send("R2 red field at bits 15:11", 32'h0000_F800, 1, 0, 24'hFF0000);
        send("R7 5-bit 10000 fills to 0x84", 32'h0000_0010, 1, 0, 24'h000084);
        send("R7 6-bit green replication", 32'h0000_0560, 1, 0, ref_rgb(32'h0000_0560, 1, 0));
        send("R2 R7 mixed 565 word", 32'h0000_A5C3, 1, 0, ref_rgb(32'h0000_A5C3, 1, 0));
    endtask

    task automatic t_bytes_mask;
        cfg_bytes_m1 = 2'd1;
        cfg_sel_red = mk_sel(8'h5A, 8, 16);
        cfg_sel_green = mk_sel(8'h5A, 8, 8);
        cfg_sel_blue = mk_sel(8'h5A, 8, 28);
        send("R6 two-byte pixel hides upper bytes", 32'h1234_5678, 1, 0, 24'h005600);
        cfg_bytes_m1 = 2'd2;
        send("R6 three-byte pixel", 32'h1234_5678, 1, 0, 24'h345600);
        cfg_bytes_m1 = 2'd3;
        send("R6 four-byte pixel, field past word end", 32'hF234_5678, 1, 0, 24'h34560F);
        cfg_bytes_m1 = 2'd0;
        send("R6 one-byte pixel", 32'h1234_5678, 1, 0, ref_rgb(32'h1234_5678, 1, 0));
    endtask

    task automatic t_wide;
        cfg_bytes_m1 = 2'd3;
        cfg_sel_red = mk_sel(8'h00, 12, 0);
        cfg_sel_green = mk_sel(8'h00, 15, 10);
        cfg_sel_blue = mk_sel(8'h00, 9, 20);
        send("R8 12-bit field keeps top byte", 32'h0000_0ABC, 1, 0,
             {8'hAB, ref_comp(32'h0000_0ABC, 3, cfg_sel_green, 1, 0),
              ref_comp(32'h0000_0ABC, 3, cfg_sel_blue, 1, 0)});
        send("R8 wide fields mixed", 32'h9E37_79B9, 1, 0, ref_rgb(32'h9E37_79B9, 1, 0));
    endtask

    task automatic t_zero_width;
        cfg_sel_red = mk_sel(8'h00, 8, 16);
        cfg_sel_green = mk_sel(8'hC3, 0, 8);
        cfg_sel_blue = mk_sel(8'h00, 8, 0);
        send("R3 zero-width green shows default", 32'h00AB_CDEF, 1, 0, 24'hABC3EF);
        send("R3 zero-width with all-ones word", 32'hFFFF_FFFF, 1, 0, 24'hFFC3FF);
    endtask

    task automatic t_blank_underrun;
        cfg_sel_red = mk_sel(8'hFF, 8, 16);
        cfg_sel_green = mk_sel(8'h00, 8, 8);
        cfg_sel_blue = mk_sel(8'h00, 8, 0);
        send("R5 underrun shows red", 32'h0012_3456, 1, 1, 24'hFF0000);
        cfg_sel_red = mk_sel(8'h21, 8, 16);
        cfg_sel_green = mk_sel(8'h43, 0, 8);
        cfg_sel_blue = mk_sel(8'h65, 8, 0);
        send("R4 outside visible shows defaults", 32'h0012_3456, 0, 0, 24'h214365);
        send("R4 R5 blanking and underrun together", 32'h0012_3456, 0, 1, 24'h214365);
        send("R4 visible again extracts", 32'h0012_3456, 1, 0, 24'h124356);
    endtask

    task automatic t_stream;
        logic [23:0] prev;
        cfg_bytes_m1 = 2'd2;
        cfg_sel_red = mk_sel(8'hFF, 6, 18);
        cfg_sel_green = mk_sel(8'h10, 7, 9);
        cfg_sel_blue = mk_sel(8'h20, 3, 2);
        for (int k = 0; k < 8; k++) begin
            logic [31:0] w;
            logic und;
            w = 32'h0135_79BD * (k + 3);
            und = (k % 3) == 1;
            in_valid = 1'b1; in_word = w; in_visible = 1'b1; in_underrun = und;
            @(negedge clk);
            check("R9 back-to-back pixel one cycle later", {out_valid, out_rgb},
                  {1'b1, ref_rgb(w, 1, und)});
            prev = ref_rgb(w, 1, und);
        end
        in_valid = 1'b0; in_underrun = 1'b0; in_word = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R10 idle cycle holds data", {out_valid, out_rgb}, {1'b0, prev});
        in_visible = 1'b0;
        @(negedge clk);
        check("R10 idle with blanking still holds", {out_valid, out_rgb}, {1'b0, prev});
        in_visible = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_layout_565();
        t_bytes_mask();
        t_wide();
        t_zero_width();
        t_blank_underrun();
        t_stream();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule